// File: doc/BRIEF.md
# Fan PWM Output Generator

This block drives a single fan pin from one 8-bit configuration byte. The byte is written over a plain write-enable byte bus, and its value can always be read back. Its lowest bit pins the output high. When that bit is clear, a 6-bit duty field sets how many steps of a 64-step period the pin stays high. The full range runs from always low (duty 0) to 63 of 64 steps high, so only the override bit gives a fully high pin.

The step counter advances on one of two external tick strobes, and the top configuration bit chooses which one. A separate doubling input adds a second step at the midpoint of the measured interval between selected ticks, which doubles the output rate. A new duty value is loaded only when the counter wraps, so a write made mid-period never cuts a pulse short.

Top module: `fan_pwm_gen`

## Requirements
- R1: After reset the configuration byte reads 0x00 and the fan pin is low.
- R2: A write (wr_en_i high at a rising edge) stores wr_data_i, and rd_data_o shows that value from the following cycle. Without a write, the stored byte holds.
- R3: While bit 0 of the byte is 1, the pin is high continuously, whatever the other bits hold. The pin goes high by the second rising edge counting the write edge.
- R4: While bit 0 is 0, the pin is high exactly while the 6-bit step counter is below the active duty value (bits 6:1). Duty 0 keeps the pin low.
- R5: Duty 32 (byte 0x40) gives a 50% duty cycle over a period of 64 steps.
- R6: Duty 63 (byte 0x7E) keeps the pin high for 63 steps and low for 1 step in every period.
- R7: Bit 7 selects the step source: 0 takes tick_a_i and 1 takes tick_b_i. With doubling off, the counter advances by one on each selected tick and at no other time.
- R8: With dbl_i high, the counter also advances at the midpoint of the last measured interval between selected ticks. For evenly spaced ticks this halves the PWM period. Measurement restarts when the source selection changes.
- R9: A new duty value is applied only when the step counter wraps from 63 to 0. Until then the previous duty stays in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Write strobe for the configuration byte |
| wr_data_i | input | 8 | Byte to store |
| rd_data_o | output | 8 | Stored configuration byte |
| tick_a_i | input | 1 | Step tick source A (one-cycle strobes) |
| tick_b_i | input | 1 | Step tick source B (one-cycle strobes) |
| dbl_i | input | 1 | Doubles the step rate when high |
| fan_o | output | 1 | Fan pin |

## Verification
The stored byte is due on the cycle after the write edge. The force bit reaches the pin one edge later, so the bench samples the pin at the second falling edge after the write. A duty change only shows after the next counter wrap, which can be up to 64 steps away. For that reason, rate and duty checks first wait several full periods and then count high cycles over a window exactly one period long; that count does not depend on phase. Period length is timed from one rising pin edge to the next. The deferred-load check samples at fixed cycle counts from reset release, once before the first wrap and once after it.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
    localparam int unsigned DUTY_W = 6;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned IVL_W  = 12;

    // bit 7: step source select, bits 6:1: duty, bit 0: force high
    typedef struct packed {
        logic              clk_sel;
        logic [DUTY_W-1:0] duty;
        logic              force_hi;
    } fan_cfg_t;
endpackage

// File: rtl/fan_cfg_reg.sv
module fan_cfg_reg
    import fan_pwm_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output fan_cfg_t         cfg_o,
    output logic [REG_W-1:0] rd_data_o
);
    typedef struct packed {
        fan_cfg_t cfg;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.cfg = fan_cfg_t'(wr_data_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o     = st_q.cfg;
    assign rd_data_o = REG_W'(st_q.cfg);
endmodule

// File: rtl/fan_tick_sel.sv
module fan_tick_sel #(
    parameter int unsigned IVL_W = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_a_i,
    input  logic tick_b_i,
    input  logic sel_i,
    input  logic dbl_i,
    output logic step_en_o
);
    typedef struct packed {
        logic [IVL_W-1:0] cnt;   // cycles since last selected tick
        logic [IVL_W-1:0] per;   // last full interval
        logic             seen;  // at least one tick since restart
        logic             sel;   // selection the measurement belongs to
    } tsel_st_t;

    tsel_st_t st_d, st_q;
    logic     tick;
    logic     mid;

    always_comb begin
        tick  = sel_i ? tick_b_i : tick_a_i;
        mid   = 1'b0;
        st_d  = st_q;
        st_d.sel = sel_i;
        if (sel_i != st_q.sel) begin
            st_d.cnt  = '0;
            st_d.per  = '0;
            st_d.seen = 1'b0;
        end else begin
            if (tick) begin
                st_d.cnt  = IVL_W'(1);
                st_d.seen = 1'b1;
                if (st_q.seen) begin
                    st_d.per = st_q.cnt;
                end
            end else if (st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            mid = dbl_i && st_q.seen && !tick &&
                  (st_q.per >= IVL_W'(2)) &&
                  (st_q.cnt == (st_q.per >> 1));
        end
        step_en_o = tick | mid;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core
    import fan_pwm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_en_i,
    input  logic              force_hi_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              fan_o,
    output logic [DUTY_W-1:0] step_o,
    output logic [DUTY_W-1:0] duty_act_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] step;
        logic [DUTY_W-1:0] duty;
        logic              fan;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en_i) begin
            st_d.step = st_q.step + 1'b1;
            if (st_q.step == '1) begin
                st_d.duty = duty_i;
            end
        end
        st_d.fan = force_hi_i | (st_d.step < st_d.duty);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fan_o      = st_q.fan;
    assign step_o     = st_q.step;
    assign duty_act_o = st_q.duty;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
    import fan_pwm_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       tick_a_i,
    input  logic       tick_b_i,
    input  logic       dbl_i,
    output logic       fan_o
);
    fan_cfg_t          cfg;
    logic              step_en;
    logic [DUTY_W-1:0] step_cnt;
    logic [DUTY_W-1:0] duty_act;

    fan_cfg_reg i_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg),
        .rd_data_o (rd_data_o)
    );

    fan_tick_sel #(.IVL_W(IVL_W)) i_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_a_i  (tick_a_i),
        .tick_b_i  (tick_b_i),
        .sel_i     (cfg.clk_sel),
        .dbl_i     (dbl_i),
        .step_en_o (step_en)
    );

    fan_pwm_core i_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_en_i  (step_en),
        .force_hi_i (cfg.force_hi),
        .duty_i     (cfg.duty),
        .fan_o      (fan_o),
        .step_o     (step_cnt),
        .duty_act_o (duty_act)
    );
endmodule

// File: rtl/fan_pwm_checker.sv
module fan_pwm_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       tick_a_i,
    input logic       tick_b_i,
    input logic       dbl_i,
    input logic       fan_o,
    input logic       step_en,
    input logic [5:0] step_cnt,
    input logic [5:0] duty_act
);
    a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> rd_data_o == $past(wr_data_i));

    a_r2_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(rd_data_o));

    a_r3_forced_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rd_data_o[0]) |-> fan_o);

    a_r4_compare: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rd_data_o[0]) |-> fan_o == (step_cnt < duty_act));

    a_r4_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(rd_data_o[0]) && duty_act == 6'd0) |-> !fan_o);

    a_r7_step_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dbl_i && !(rd_data_o[7] ? tick_b_i : tick_a_i)) |-> !step_en);

    a_r7_step_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_en |=> step_cnt == 6'($past(step_cnt) + 6'd1));

    a_r7_step_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_en |=> $stable(step_cnt));

    a_r9_duty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(step_en && step_cnt == 6'd63) |=> $stable(duty_act));

    a_r9_duty_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_en && step_cnt == 6'd63) |=> duty_act == $past(rd_data_o[6:1]));
endmodule

bind fan_pwm_gen fan_pwm_checker i_fan_pwm_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .tick_a_i  (tick_a_i),
    .tick_b_i  (tick_b_i),
    .dbl_i     (dbl_i),
    .fan_o     (fan_o),
    .step_en   (step_en),
    .step_cnt  (step_cnt),
    .duty_act  (duty_act)
);

// File: tb/test_fan_pwm_gen.sv
module test_fan_pwm_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick_a = 1'b0;
    logic       tick_b = 1'b0;
    logic       dbl = 1'b0;
    logic       fan;
    int         checks = 0;
    int         errors = 0;
    int         tcnt = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    fan_pwm_gen i_fan_pwm_gen (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .tick_a_i  (tick_a),
        .tick_b_i  (tick_b),
        .dbl_i     (dbl),
        .fan_o     (fan)
    );

    // tick A every 4 cycles, tick B every 8 cycles, phase restarts at reset
    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt   <= 0;
            tick_a <= 1'b0;
            tick_b <= 1'b0;
        end else begin
            tick_a <= (tcnt % 4) == 3;
            tick_b <= (tcnt % 8) == 7;
            tcnt   <= tcnt + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  cfg;
        logic        dbl;
        logic [15:0] period;
        logic [15:0] high;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h40, 1'b0, 16'd256, 16'd128, 4'd5},
        '{8'h7E, 1'b0, 16'd256, 16'd252, 4'd6},
        '{8'h02, 1'b0, 16'd256, 16'd4,   4'd4},
        '{8'h00, 1'b0, 16'd256, 16'd0,   4'd4},
        '{8'h20, 1'b0, 16'd256, 16'd64,  4'd4},
        '{8'h01, 1'b0, 16'd256, 16'd256, 4'd3},
        '{8'hC0, 1'b0, 16'd512, 16'd256, 4'd7},
        '{8'hFF, 1'b0, 16'd512, 16'd512, 4'd3},
        '{8'h40, 1'b1, 16'd128, 16'd64,  4'd8},
        '{8'hC0, 1'b1, 16'd256, 16'd128, 4'd8},
        '{8'hFE, 1'b1, 16'd256, 16'd252, 4'd8}
    };

    function automatic string req_tag(input logic [3:0] r);
        case (r)
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic count_high(input int len, output int hi);
        hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (fan) hi++;
        end
    endtask

    task automatic meas_period(output int p);
        int n;
        n = 0;
        while (fan !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
        while (fan !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        p = 0;
        while (fan === 1'b1 && p < 5000) begin @(negedge clk); p++; end
        while (fan === 1'b0 && p < 5000) begin @(negedge clk); p++; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int hi;
        int per;
        do_reset();

        // R1: reset state
        check("R1 reset read", int'(rd_data), 0);
        check("R1 reset pin", int'(fan), 0);

        // R2 / R9: write right after reset; duty must wait for the first wrap
        write_cfg(8'h7E);
        check("R2 readback", int'(rd_data), 8'h7E);
        repeat (120) @(negedge clk);
        check("R9 old duty kept before wrap", int'(fan), 0);
        repeat (200) @(negedge clk);
        check("R9 new duty after wrap", int'(fan), 1);

        // R3: force reaches pin on the second edge
        write_cfg(8'h00);
        repeat (600) @(negedge clk);
        check("R4 duty zero low", int'(fan), 0);
        write_cfg(8'h01);
        @(negedge clk);
        check("R3 force latency", int'(fan), 1);

        // stimulus table
        for (int v = 0; v < NV; v++) begin
            dbl = VECS[v].dbl;
            write_cfg(VECS[v].cfg);
            check({req_tag(VECS[v].req), " readback"}, int'(rd_data), int'(VECS[v].cfg));
            repeat (1600) @(negedge clk);
            count_high(int'(VECS[v].period), hi);
            check({req_tag(VECS[v].req), " high cycles"}, hi, int'(VECS[v].high));
            if (VECS[v].high != 16'd0 && VECS[v].high != VECS[v].period) begin
                meas_period(per);
                check({req_tag(VECS[v].req), " period"}, per, int'(VECS[v].period));
            end
        end
        dbl = 1'b0;

        // R2: no write, byte holds
        repeat (50) @(negedge clk);
        check("R2 hold without write", int'(rd_data), 8'hFE);

        // R1: reset during operation
        write_cfg(8'h7F);
        repeat (10) @(negedge clk);
        do_reset();
        check("R1 mid-run reset read", int'(rd_data), 0);
        check("R1 mid-run reset pin", int'(fan), 0);
        repeat (300) @(negedge clk);
        check("R1 pin stays low after reset", int'(fan), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule